// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block sits behind a byte-level serial bus front end and in front of a byte-wide nonvolatile array, modelled here as plain registers. The front end decodes bus traffic into single-cycle strobes: load the pointer, write a data byte, read a data byte, stop seen, repeated start seen. The block keeps an address pointer and a small page buffer. Data bytes land in the page buffer and move to the array only after a stop, through a timed programming cycle. A repeated start discards them instead.

While a programming cycle runs, the block raises `busy`. The front end uses this flag to withhold acknowledges, and every strobe is ignored. Reads take the byte under the pointer and then advance the pointer across the whole address space. Writes advance only the in-page bits of the pointer, so a long burst folds back onto the start of its page.

The controller is one state machine with three states:
- `ST_IDLE`: accepts pointer loads, reads and the first data byte.
- `ST_FILL`: collects data bytes until a stop or a repeated start.
- `ST_PROG`: counts the programming delay.

Its transitions are:
- IDLE→FILL on a data byte.
- FILL→FILL on a further data byte.
- FILL→PROG on a stop.
- FILL→IDLE on a repeated start (discard).
- PROG→PROG while the delay counter is non-zero.
- PROG→IDLE when the counter is zero (commit).

Top module: `nvm_page_writer`

## Requirements
- R1: After reset, `busy` is 0, `ptr` is 00h and every array byte reads 00h.
- R2: In ST_IDLE, `ptr_load` copies `din` into the pointer, and `rd_data` then shows the array byte at that address. `ptr_load` takes priority over `wr_stb` and `rd_stb`.
- R3: A data byte (`wr_stb`) is placed in page slot `ptr[2:0]`. Then only `ptr[2:0]` increments, modulo 8, and `ptr[7:3]` is unchanged.
- R4: More than 8 data bytes in one burst overwrite earlier slots. Writing 00h,11h,…,99h starting at 00h leaves 88h,99h,22h,33h,44h,55h,66h,77h at 00h–07h.
- R5: A stop (`stop_evt`) in ST_FILL raises `busy` for exactly PROG_CYCLES clock cycles. The array contents change only in the cycle where `busy` falls. Before that, `rd_data` stays stable.
- R6: A commit writes only the slots that received a byte in the burst. Other bytes of the page keep their old values.
- R7: A repeated start (`restart_evt`) in ST_FILL discards the buffered bytes. `busy` stays 0 and the array is unchanged. `restart_evt` has priority over `stop_evt`.
- R8: While `busy` is 1, every strobe is ignored: the pointer, the array and the buffered state are unaffected.
- R9: In ST_IDLE, `rd_data` is the array byte at `ptr`. `rd_stb` increments the full 8-bit pointer, wrapping from FFh to 00h. Reading 30 bytes from 04h reads 21h last and leaves `ptr` at 22h.
- R10: A stop or repeated start in ST_IDLE, with no buffered bytes, has no effect: `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_load | input | 1 | Load the pointer from `din` |
| wr_stb | input | 1 | `din` is a data byte to buffer |
| rd_stb | input | 1 | Current read byte consumed; advance the pointer |
| stop_evt | input | 1 | Stop condition seen on the bus |
| restart_evt | input | 1 | Repeated start seen on the bus |
| din | input | 8 | Byte from the front end |
| rd_data | output | 8 | Array byte at the pointer |
| ptr | output | 8 | Current address pointer |
| busy | output | 1 | Programming cycle in progress |

## Verification
Directed bursts cover several cases:
- A ten-byte run from 00h, which separates in-page rollover from full-pointer increment.
- A two-byte burst into a page already filled, which exposes a commit that writes unwritten slots.
- An aborted burst, which separates discard from commit.
- Reads from 04h and from FEh, which tell the full-space wrap apart from the page wrap.

Strobes issued during a programming cycle show whether `busy` really blocks access. Seeded random bursts of 1 to 12 bytes at random addresses, ended by a random choice of stop or repeated start and then read back page-wide, cover slot placement, mask handling and commit timing.

// File: rtl/nvpw_pkg.sv
package nvpw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PROG = 2'd2
    } wstate_t;
endpackage

// File: rtl/nvpw_page_buf.sv
module nvpw_page_buf #(
    parameter int DW = 8,
    parameter int IW = 3,
    localparam int SLOTS = 1 << IW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IW-1:0]              wr_idx,
    input  logic [DW-1:0]              wr_data,
    input  logic                       clear,
    output logic [SLOTS-1:0][DW-1:0]   slot_data,
    output logic [SLOTS-1:0]           slot_mask
);
    logic [SLOTS-1:0] hit;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign hit[s] = wr_en && (wr_idx == IW'(s));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_data <= '0;
            slot_mask <= '0;
        end else if (clear) begin
            slot_mask <= '0;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (hit[s]) begin
                    slot_data[s] <= wr_data;
                    slot_mask[s] <= 1'b1;
                end
            end
        end
    end

    assert_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (slot_mask == '0));

    assert_slot_marked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> slot_mask[$past(wr_idx)]);
endmodule

// File: rtl/nvpw_array.sv
module nvpw_array #(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int IW = 3,
    localparam int DEPTH = 1 << AW,
    localparam int SLOTS = 1 << IW,
    localparam int PW = AW - IW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [PW-1:0]              page_base,
    input  logic [SLOTS-1:0][DW-1:0]   slot_data,
    input  logic [SLOTS-1:0]           slot_mask,
    input  logic [AW-1:0]              rd_addr,
    output logic [DW-1:0]              rd_data
);
    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] wen;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            assign wen[g] = commit && (page_base == PW'(g >> IW)) && slot_mask[g % SLOTS];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wen[i]) mem[i] <= slot_data[i[IW-1:0]];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvm_page_writer.sv
module nvm_page_writer #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int PROG_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              stop_evt,
    input  logic              restart_evt,
    input  logic [7:0]        din,
    output logic [7:0]        rd_data,
    output logic [7:0]        ptr,
    output logic              busy
);
    import nvpw_pkg::*;

    localparam int SLOTS = 1 << PAGE_W;
    localparam int PW    = ADDR_W - PAGE_W;
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    wstate_t               state_q, state_d;
    logic [CNT_W-1:0]      cnt_q;
    logic [ADDR_W-1:0]     ptr_q;
    logic                  buf_wr, buf_clr, commit, ptr_ld, rd_step, cnt_load;
    logic [SLOTS-1:0][DATA_W-1:0] slot_data;
    logic [SLOTS-1:0]      slot_mask;
    logic [DATA_W-1:0]     arr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        buf_wr   = 1'b0;
        buf_clr  = 1'b0;
        commit   = 1'b0;
        ptr_ld   = 1'b0;
        rd_step  = 1'b0;
        cnt_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ptr_load) begin
                    ptr_ld = 1'b1;
                end else if (wr_stb) begin
                    buf_wr  = 1'b1;
                    state_d = ST_FILL;
                end else if (rd_stb) begin
                    rd_step = 1'b1;
                end
            end
            ST_FILL: begin
                if (restart_evt) begin
                    buf_clr = 1'b1;
                    state_d = ST_IDLE;
                end else if (stop_evt) begin
                    cnt_load = 1'b1;
                    state_d  = ST_PROG;
                end else if (wr_stb) begin
                    buf_wr = 1'b1;
                end
            end
            ST_PROG: begin
                if (cnt_q == '0) begin
                    commit  = 1'b1;
                    buf_clr = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            if (ptr_ld)
                ptr_q <= ADDR_W'(din);
            else if (buf_wr)
                ptr_q <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
            else if (rd_step)
                ptr_q <= ptr_q + 1'b1;
            if (cnt_load)
                cnt_q <= CNT_W'(PROG_CYCLES - 1);
            else if (state_q == ST_PROG && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    nvpw_page_buf #(.DW(DATA_W), .IW(PAGE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (buf_wr),
        .wr_idx    (ptr_q[PAGE_W-1:0]),
        .wr_data   (DATA_W'(din)),
        .clear     (buf_clr),
        .slot_data (slot_data),
        .slot_mask (slot_mask)
    );

    nvpw_array #(.AW(ADDR_W), .DW(DATA_W), .IW(PAGE_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .page_base (ptr_q[ADDR_W-1:PAGE_W]),
        .slot_data (slot_data),
        .slot_mask (slot_mask),
        .rd_addr   (ptr_q),
        .rd_data   (arr_q)
    );

    assign rd_data = 8'(arr_q);
    assign ptr     = 8'(ptr_q);
    assign busy    = (state_q == ST_PROG);

    assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr_q));

    assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));

    assert_read_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && ptr_q == {ADDR_W{1'b1}}) |=> (ptr_q == '0));

    assert_stop_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && stop_evt && !restart_evt) |=> busy);

    assert_no_early_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> $stable(rd_data));

    assert_idle_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_stb) |=> !busy);
endmodule

// File: tb/nvm_page_writer_bench.sv
module nvm_page_writer_bench;
    localparam int PROG = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ptr_load = 0, wr_stb = 0, rd_stb = 0, stop_evt = 0, restart_evt = 0;
    logic [7:0] din = 8'h00;
    logic [7:0] rd_data, ptr;
    logic busy;

    int errors = 0, checks = 0;
    bit finished = 0;

    logic [7:0] bmem [256];
    logic [7:0] bptr;
    logic [7:0] pbuf [8];
    logic [7:0] pmask;

    nvm_page_writer #(.PROG_CYCLES(PROG)) u_nvm_page_writer (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .stop_evt(stop_evt), .restart_evt(restart_evt), .din(din),
        .rd_data(rd_data), .ptr(ptr), .busy(busy)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] page_step(input logic [7:0] p);
        return {p[7:3], p[2:0] + 3'd1};
    endfunction

    function automatic logic [7:0] exp_read();
        return bmem[bptr];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic pl, input logic wr, input logic rd, input logic sp,
                       input logic rs, input logic [7:0] d);
        @(negedge clk);
        ptr_load = pl; wr_stb = wr; rd_stb = rd; stop_evt = sp; restart_evt = rs; din = d;
        @(negedge clk);
        ptr_load = 0; wr_stb = 0; rd_stb = 0; stop_evt = 0; restart_evt = 0;
    endtask

    task automatic do_load(input logic [7:0] a);
        cyc(1, 0, 0, 0, 0, a);
        bptr = a;
        check(ptr == bptr, "R2 ptr load", ptr, bptr);
    endtask

    task automatic do_write(input logic [7:0] d);
        cyc(0, 1, 0, 0, 0, d);
        pbuf[bptr[2:0]] = d;
        pmask[bptr[2:0]] = 1'b1;
        bptr = page_step(bptr);
    endtask

    task automatic model_commit();
        for (int i = 0; i < 8; i++)
            if (pmask[i]) bmem[{bptr[7:3], 3'(i)}] = pbuf[i];
        pmask = '0;
    endtask

    task automatic do_stop();
        int n;
        cyc(0, 0, 0, 1, 0, 8'h00);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == PROG, "R5 busy length", n, PROG);
        model_commit();
    endtask

    task automatic do_restart();
        cyc(0, 0, 0, 0, 1, 8'h00);
        check(busy == 1'b0, "R7 no busy after abort", busy, 0);
        pmask = '0;
    endtask

    task automatic do_read(input string req);
        check(rd_data == exp_read(), req, rd_data, exp_read());
        cyc(0, 0, 1, 0, 0, 8'h00);
        bptr = bptr + 8'd1;
    endtask

    task automatic check_page(input logic [7:0] base, input string req);
        do_load({base[7:3], 3'd0});
        for (int i = 0; i < 8; i++) do_read(req);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
        bptr = 8'h00;
        pmask = '0;
        for (int i = 0; i < 8; i++) pbuf[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check(busy == 0, "R1 busy at reset", busy, 0);
        check(ptr == 0, "R1 ptr at reset", ptr, 0);
        check(rd_data == 0, "R1 data at reset", rd_data, 0);
        check_page(8'h40, "R1 array zero");

        // R4: ten-byte burst folds within the page
        do_load(8'h00);
        for (int i = 0; i < 10; i++) do_write(8'(i * 8'h11));
        check(ptr == 8'h02, "R3 low bits wrap", ptr, 8'h02);
        do_stop();
        do_load(8'h00);
        check(rd_data == 8'h88, "R4 byte 00h", rd_data, 8'h88);
        cyc(0, 0, 1, 0, 0, 8'h00); bptr = bptr + 1;
        check(rd_data == 8'h99, "R4 byte 01h", rd_data, 8'h99);
        check_page(8'h00, "R4 page contents");

        // R6: partial burst into a filled page
        do_load(8'h10);
        for (int i = 0; i < 8; i++) do_write(8'(8'hE0 + i));
        do_stop();
        do_load(8'h13);
        do_write(8'hAB);
        do_write(8'hCD);
        check(ptr == 8'h15, "R3 pointer after two bytes", ptr, 8'h15);
        do_stop();
        check_page(8'h10, "R6 unwritten slots kept");

        // R7: abort, then stop in idle (R10)
        do_load(8'h20);
        do_write(8'h55);
        do_write(8'h66);
        do_restart();
        cyc(0, 0, 0, 1, 0, 8'h00);
        check(busy == 0, "R10 stop in idle", busy, 0);
        cyc(0, 0, 0, 0, 1, 8'h00);
        check(busy == 0, "R10 restart in idle", busy, 0);
        check_page(8'h20, "R7 aborted data not saved");

        // R8: strobes during programming
        do_load(8'h30);
        do_write(8'h3C);
        cyc(0, 0, 0, 1, 0, 8'h00);
        cyc(1, 0, 0, 0, 0, 8'h5A);
        cyc(0, 1, 0, 0, 0, 8'h77);
        cyc(0, 0, 1, 0, 0, 8'h00);
        check(busy == 1, "R8 still busy", busy, 1);
        check(ptr == bptr, "R8 ptr frozen", ptr, bptr);
        while (busy) @(negedge clk);
        model_commit();
        check(ptr == bptr, "R8 ptr after busy", ptr, bptr);
        check_page(8'h30, "R8 noise not written");
        check_page(8'h58, "R8 no write at loaded address");

        // R9: long read and full wrap
        do_load(8'h04);
        for (int i = 0; i < 29; i++) do_read("R9 sequential read");
        check(ptr == 8'h21, "R9 last address read", ptr, 8'h21);
        do_read("R9 byte at 21h");
        check(ptr == 8'h22, "R9 ptr after 30 reads", ptr, 8'h22);
        do_load(8'hFE);
        for (int i = 0; i < 3; i++) do_read("R9 wrap read");
        check(ptr == 8'h01, "R9 wrap FFh to 00h", ptr, 8'h01);

        // random bursts
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h1234);
        end
        for (int it = 0; it < 40; it++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom);
            n = 1 + ($urandom % 12);
            do_load(a);
            for (int k = 0; k < n; k++) do_write(8'($urandom));
            check(ptr[7:3] == a[7:3], "R3 page fixed", ptr, a);
            if (($urandom % 4) != 0) do_stop();
            else do_restart();
            check_page(a, "R5 random readback");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule